// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the frequency of a fractional-N PLL without software having to time each step. A single start pulse carries the new divider set, a range code, the length of the reset hold in microseconds and the requested output rate in MHz. The block first checks that rate against a lower and an upper limit. If the rate is out of range it refuses the request and leaves the PLL alone. If the rate is in range it stops the downstream clock, puts the PLL in bypass and holds it in reset. It then writes the encoded divider fields and the range code, waits out the reset hold and releases reset. It polls the lock indication once per microsecond for a bounded number of samples, takes the PLL out of bypass and finally lets the downstream clock run again.

Each output is driven straight from a register. Time is counted in clock cycles through a clocks-per-microsecond parameter. The lock input comes from the analog macro, so it passes through a synchronizer before use. When lock is not seen in time, the sequence still finishes; the failure is only reported on a status flag.

Top module: `pll_reprog_seq`

## Requirements
- R1: After a start pulse with an accepted rate, `hold_dn_clk` and `busy` rise on the next edge, `pll_bypass` rises one edge later, and `pll_reset` rises one edge after that. Each step is one cycle apart.
- R2: One edge after reset rises, the divider fields are loaded. `pll_ref_f` = ref_div-1, `pll_fbi_f` = fb_int-1 (9 bits), `pll_frac_f` = fb_frac unchanged (24 bits), and `pll_pdiv_f` = post_div/2-1. The fields change at no other time.
- R3: `pll_range` takes the new range code one edge after the divider fields, while reset is still high.
- R4: Reset falls exactly max(rst_us,1)*CLKS_PER_US cycles after the range code is written. During that wait, `pll_lock` is ignored.
- R5: After reset falls, lock is sampled every CLKS_PER_US cycles, with the first sample at the CLKS_PER_US-th edge. Lock passes through SYNC_STAGES flops before sampling. Bypass clears on the first sample that sees lock.
- R6: If LOCK_POLLS samples all miss lock, bypass still clears at the last sample (LOCK_POLLS*CLKS_PER_US cycles after release) and `lock_timeout` is set.
- R7: One edge after bypass clears, `hold_dn_clk` and `busy` fall and `done` pulses for one cycle. `lock_timeout` holds its value until the next accepted start, which clears it.
- R8: A start whose `req_rate` is below MIN_RATE or above MAX_RATE (both limits inclusive-accepted) pulses `rejected` for one cycle on the next edge. No other output changes.
- R9: While `busy` is high, start requests are ignored. The fields of the running change are kept and `rejected` stays low.
- R10: After reset, every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; sampled only when idle |
| req_rate | input | RATE_W | Requested output rate in MHz |
| ref_div | input | REF_W+1 | Reference divider value |
| fb_int | input | FBI_W+1 | Integer feedback divider value |
| fb_frac | input | FRAC_W | Fractional feedback divider |
| post_div | input | PDIV_W+2 | Output divider value (even) |
| range_code | input | RANGE_W | PLL input range code |
| rst_us | input | RST_US_W | Reset hold in microseconds (0 means 1) |
| pll_lock | input | 1 | Asynchronous lock indication |
| pll_bypass | output | 1 | PLL bypass control |
| pll_reset | output | 1 | PLL reset control |
| pll_ref_f | output | REF_W | Reference divider field |
| pll_fbi_f | output | FBI_W | Integer feedback field |
| pll_frac_f | output | FRAC_W | Fractional feedback field |
| pll_pdiv_f | output | PDIV_W | Output divider field |
| pll_range | output | RANGE_W | Range code |
| hold_dn_clk | output | 1 | Keeps the downstream clock stopped |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle pulse when a change ends |
| lock_timeout | output | 1 | Last change ended without lock |
| rejected | output | 1 | One-cycle pulse for an out-of-range request |

## Verification
The first results of a change appear at fixed distances from the edge that accepts start. The gate, bypass, reset, fields and range appear one to five edges later, so the bench samples each of them just after its own edge. The reset release is due max(rst_us,1)*CLKS_PER_US edges after the range write, and the bypass release is due after a number of edges that the bench computes from the lock delay, the synchronizer depth and the sampling grid. The bench counts edges from the preceding event and compares that count with the computed one, so an early or late transition of even one cycle is reported. Done, the gate release and the timeout flag are checked exactly one edge after the bypass release, and rejection one edge after start.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYP,
    ST_RST,
    ST_PROG,
    ST_RNG,
    ST_RWAIT,
    ST_POLL,
    ST_FIN
  } seq_state_t;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pll_field_enc.sv
module pll_field_enc #(
  parameter int REF_W   = 6,
  parameter int FBI_W   = 9,
  parameter int PDIV_W  = 5
) (
  input  logic [REF_W:0]    ref_div,
  input  logic [FBI_W:0]    fb_int,
  input  logic [PDIV_W+1:0] post_div,
  output logic [REF_W-1:0]  ref_f,
  output logic [FBI_W-1:0]  fbi_f,
  output logic [PDIV_W-1:0] pdiv_f
);
  logic [REF_W:0]    ref_m1;
  logic [FBI_W:0]    fbi_m1;
  logic [PDIV_W+1:0] half_m1;

  always_comb begin
    ref_m1  = ref_div - 1'b1;
    fbi_m1  = fb_int - 1'b1;
    half_m1 = (post_div >> 1) - 1'b1;
    ref_f   = ref_m1[REF_W-1:0];
    fbi_f   = fbi_m1[FBI_W-1:0];
    pdiv_f  = half_m1[PDIV_W-1:0];
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R4: the controller never counts below zero
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> cnt != '0);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int LOCK_POLLS  = 120,
  parameter int SYNC_STAGES = 2,
  parameter int RATE_W      = 12,
  parameter int MIN_RATE    = 20,
  parameter int MAX_RATE    = 1600,
  parameter int REF_W       = 6,
  parameter int FBI_W       = 9,
  parameter int FRAC_W      = 24,
  parameter int PDIV_W      = 5,
  parameter int RANGE_W     = 3,
  parameter int RST_US_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [RATE_W-1:0]   req_rate,
  input  logic [REF_W:0]      ref_div,
  input  logic [FBI_W:0]      fb_int,
  input  logic [FRAC_W-1:0]   fb_frac,
  input  logic [PDIV_W+1:0]   post_div,
  input  logic [RANGE_W-1:0]  range_code,
  input  logic [RST_US_W-1:0] rst_us,
  input  logic                pll_lock,
  output logic                pll_bypass,
  output logic                pll_reset,
  output logic [REF_W-1:0]    pll_ref_f,
  output logic [FBI_W-1:0]    pll_fbi_f,
  output logic [FRAC_W-1:0]   pll_frac_f,
  output logic [PDIV_W-1:0]   pll_pdiv_f,
  output logic [RANGE_W-1:0]  pll_range,
  output logic                hold_dn_clk,
  output logic                busy,
  output logic                done,
  output logic                lock_timeout,
  output logic                rejected
);
  localparam int CW = $clog2((2 ** RST_US_W) * CLKS_PER_US + 1);
  localparam int PW = $clog2(LOCK_POLLS + 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(LOCK_POLLS - 1);
  localparam logic [CW-1:0] US_M1     = CW'(CLKS_PER_US - 1);

  seq_state_t state;

  logic [REF_W-1:0]    enc_ref, q_ref;
  logic [FBI_W-1:0]    enc_fbi, q_fbi;
  logic [PDIV_W-1:0]   enc_pdiv, q_pdiv;
  logic [FRAC_W-1:0]   q_frac;
  logic [RANGE_W-1:0]  q_rng;
  logic [RST_US_W-1:0] q_rus;
  logic [PW-1:0]       polls;
  logic                lock_s, rate_ok;
  logic                tmr_load, tmr_dec, tmr_zero;
  logic [CW-1:0]       tmr_val, wait_m1;
  logic [RST_US_W-1:0] rus_eff;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pll_lock), .q(lock_s)
  );

  pll_field_enc #(.REF_W(REF_W), .FBI_W(FBI_W), .PDIV_W(PDIV_W)) u_enc (
    .ref_div(ref_div), .fb_int(fb_int), .post_div(post_div),
    .ref_f(enc_ref), .fbi_f(enc_fbi), .pdiv_f(enc_pdiv)
  );

  pll_seq_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .zero(tmr_zero)
  );

  always_comb begin
    rate_ok = (req_rate >= RATE_W'(MIN_RATE)) && (req_rate <= RATE_W'(MAX_RATE));
    rus_eff = (q_rus == '0) ? RST_US_W'(1) : q_rus;
    wait_m1 = CW'(rus_eff) * CW'(CLKS_PER_US) - CW'(1);
  end

  // timer control: one load per phase, decrement otherwise
  always_comb begin
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = US_M1;
    case (state)
      ST_RNG: begin
        tmr_load = 1'b1;
        tmr_val  = wait_m1;
      end
      ST_RWAIT, ST_POLL: begin
        if (tmr_zero) tmr_load = 1'b1;
        else          tmr_dec  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      pll_bypass   <= 1'b0;
      pll_reset    <= 1'b0;
      pll_ref_f    <= '0;
      pll_fbi_f    <= '0;
      pll_frac_f   <= '0;
      pll_pdiv_f   <= '0;
      pll_range    <= '0;
      hold_dn_clk  <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      lock_timeout <= 1'b0;
      rejected     <= 1'b0;
      polls        <= '0;
      q_ref        <= '0;
      q_fbi        <= '0;
      q_frac       <= '0;
      q_pdiv       <= '0;
      q_rng        <= '0;
      q_rus        <= '0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (rate_ok) begin
              hold_dn_clk  <= 1'b1;
              busy         <= 1'b1;
              lock_timeout <= 1'b0;
              q_ref        <= enc_ref;
              q_fbi        <= enc_fbi;
              q_frac       <= fb_frac;
              q_pdiv       <= enc_pdiv;
              q_rng        <= range_code;
              q_rus        <= rst_us;
              state        <= ST_BYP;
            end else begin
              rejected <= 1'b1;
            end
          end
        end
        ST_BYP: begin
          pll_bypass <= 1'b1;
          state      <= ST_RST;
        end
        ST_RST: begin
          pll_reset <= 1'b1;
          state     <= ST_PROG;
        end
        ST_PROG: begin
          pll_ref_f  <= q_ref;
          pll_fbi_f  <= q_fbi;
          pll_frac_f <= q_frac;
          pll_pdiv_f <= q_pdiv;
          state      <= ST_RNG;
        end
        ST_RNG: begin
          pll_range <= q_rng;
          state     <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (tmr_zero) begin
            pll_reset <= 1'b0;
            polls     <= '0;
            state     <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tmr_zero) begin
            if (lock_s) begin
              pll_bypass <= 1'b0;
              state      <= ST_FIN;
            end else if (polls == LAST_POLL) begin
              pll_bypass   <= 1'b0;
              lock_timeout <= 1'b1;
              state        <= ST_FIN;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        ST_FIN: begin
          hold_dn_clk <= 1'b0;
          busy        <= 1'b0;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: bypass and reset only rise inside a gated change, in order
  assert_bypass_gated_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_bypass) |-> hold_dn_clk);
  assert_reset_after_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_reset) |-> (pll_bypass && hold_dn_clk));

  // R2: divider fields only move while the PLL is held in reset
  assert_fields_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable({pll_ref_f, pll_fbi_f, pll_frac_f, pll_pdiv_f}) |-> pll_reset);

  // R3: range moves in reset, after the dividers have settled
  assert_range_after_div_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(pll_range) |-> (pll_reset && $stable({pll_ref_f, pll_fbi_f, pll_frac_f, pll_pdiv_f})));

  // R5: reset is released while still bypassed
  assert_release_bypassed_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_reset) |-> pll_bypass);

  // R6: poll count never runs past its bound
  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (rst)
    polls <= LAST_POLL);

  // R7: gate released only after bypass has already cleared
  assert_gate_after_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_dn_clk) |-> (!pll_bypass && !$past(pll_bypass)));
  assert_done_clean_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!hold_dn_clk && !pll_bypass && !pll_reset && !busy));

  // R8: a refused request leaves the PLL untouched
  assert_reject_idle_R8: assert property (@(posedge clk) disable iff (rst)
    rejected |-> (!busy && !hold_dn_clk && !pll_bypass));

  // R9: no refusal is ever reported during a change
  assert_busy_no_reject_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rejected);
endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb_top;
  localparam int CPU   = 4;
  localparam int POLLS = 120;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [11:0] req_rate = '0;
  logic [6:0]  ref_div = 7'd1;
  logic [9:0]  fb_int = 10'd1;
  logic [23:0] fb_frac = '0;
  logic [6:0]  post_div = 7'd2;
  logic [2:0]  range_code = '0;
  logic [7:0]  rst_us = '0;
  logic        pll_lock = 1'b0;
  logic        pll_bypass, pll_reset, hold_dn_clk, busy, done, lock_timeout, rejected;
  logic [5:0]  pll_ref_f;
  logic [8:0]  pll_fbi_f;
  logic [23:0] pll_frac_f;
  logic [4:0]  pll_pdiv_f;
  logic [2:0]  pll_range;

  int n_chk  = 0;
  int n_fail = 0;
  logic [43:0] prev_f  = '0;
  logic [2:0]  prev_rg = '0;

  always #5 clk = ~clk;

  pll_reprog_seq #(.CLKS_PER_US(CPU), .LOCK_POLLS(POLLS), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .start(start), .req_rate(req_rate), .ref_div(ref_div),
    .fb_int(fb_int), .fb_frac(fb_frac), .post_div(post_div), .range_code(range_code),
    .rst_us(rst_us), .pll_lock(pll_lock), .pll_bypass(pll_bypass), .pll_reset(pll_reset),
    .pll_ref_f(pll_ref_f), .pll_fbi_f(pll_fbi_f), .pll_frac_f(pll_frac_f),
    .pll_pdiv_f(pll_pdiv_f), .pll_range(pll_range), .hold_dn_clk(hold_dn_clk),
    .busy(busy), .done(done), .lock_timeout(lock_timeout), .rejected(rejected)
  );

  function automatic logic [43:0] cur_f();
    return {pll_ref_f, pll_fbi_f, pll_frac_f, pll_pdiv_f};
  endfunction

  function automatic logic [43:0] enc_f(logic [6:0] rd, logic [9:0] fi, logic [23:0] ff,
                                        logic [6:0] pd);
    logic [6:0] a; logic [9:0] b; logic [6:0] c;
    a = rd - 7'd1; b = fi - 10'd1; c = (pd >> 1) - 7'd1;
    return {a[5:0], b[8:0], ff, c[4:0]};
  endfunction

  // edges after reset release at which bypass should clear; sets to_exp
  function automatic int exp_unbyp(int mode, int d, output bit to_exp);
    int need, n;
    to_exp = 1'b0;
    if (mode == 2) return CPU;
    if (mode == 0) begin to_exp = 1'b1; return POLLS * CPU; end
    need = d + SYNC + 1;
    n = (need + CPU - 1) / CPU;
    if (n < 1) n = 1;
    if (n > POLLS) begin to_exp = 1'b1; return POLLS * CPU; end
    return n * CPU;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic reject_req(input logic [11:0] rate);
    logic [43:0] f0; logic [2:0] r0;
    f0 = cur_f(); r0 = pll_range;
    req_rate = rate; ref_div = 7'd9; fb_int = 10'd77; range_code = ~r0;
    start = 1'b1; step(); start = 1'b0;
    chk(rejected && !busy && !hold_dn_clk && !pll_bypass && !pll_reset, "R8 refused",
        {rejected, busy, hold_dn_clk, pll_bypass, pll_reset}, 5'b10000);
    chk(cur_f() == f0 && pll_range == r0, "R8 fields untouched", cur_f(), f0);
    step();
    chk(!rejected && !busy, "R8 single pulse", rejected, 0);
  endtask

  // mode: 0 never locks, 1 lock after d edges from release, 2 lock during reset wait
  task automatic run_seq(input logic [11:0] rate, input logic [6:0] rd, input logic [9:0] fi,
                         input logic [23:0] ff, input logic [6:0] pd, input logic [2:0] rg,
                         input logic [7:0] rus, input int mode, input int d, input bit intr);
    logic [43:0] ef; int w, k, kexp; bit to_exp;
    ef = enc_f(rd, fi, ff, pd);
    w = ((rus == 0) ? 1 : int'(rus)) * CPU;
    kexp = exp_unbyp(mode, d, to_exp);
    pll_lock = 1'b0;
    req_rate = rate; ref_div = rd; fb_int = fi; fb_frac = ff; post_div = pd;
    range_code = rg; rst_us = rus;
    start = 1'b1; step(); start = 1'b0;
    chk(hold_dn_clk && busy && !pll_bypass && !pll_reset, "R1 gate first",
        {hold_dn_clk, busy, pll_bypass, pll_reset}, 4'b1100);
    chk(!lock_timeout, "R7 flag cleared by start", lock_timeout, 0);
    step();
    chk(pll_bypass && !pll_reset, "R1 bypass second", {pll_bypass, pll_reset}, 2'b10);
    step();
    chk(pll_reset && cur_f() == prev_f, "R1 reset third, R2 fields not yet written",
        cur_f(), prev_f);
    step();
    chk(cur_f() == ef && pll_range == prev_rg, "R2 field encoding", cur_f(), ef);
    step();
    chk(pll_range == rg && pll_reset, "R3 range after dividers", pll_range, rg);
    if (intr) begin
      req_rate = 12'd5; ref_div = rd + 7'd3; fb_int = fi ^ 10'h5; range_code = ~rg;
      rst_us = 8'd0; start = 1'b1;
    end
    if (mode == 2) pll_lock = 1'b1;
    k = 0;
    do begin
      step(); k++;
      if (intr && k == 1) begin
        start = 1'b0;
        chk(!rejected && busy, "R9 start ignored while busy", rejected, 0);
      end
    end while (pll_reset && k < 70000);
    chk(k == w, "R4 reset hold length", k, w);
    k = 0;
    do begin
      step(); k++;
      if (pll_bypass && mode == 1 && k == d) pll_lock = 1'b1;
    end while (pll_bypass && k < POLLS * CPU + 20);
    chk(k == kexp, to_exp ? "R6 bypass cleared at poll limit" : "R5 bypass cleared on lock",
        k, kexp);
    chk(hold_dn_clk && !done, "R7 gate held while bypass clears", hold_dn_clk, 1);
    step();
    chk(!hold_dn_clk && done && !busy, "R7 gate release with done",
        {hold_dn_clk, done, busy}, 3'b010);
    chk(lock_timeout == to_exp, "R6 timeout flag", lock_timeout, to_exp);
    step();
    chk(!done && lock_timeout == to_exp, "R7 done single pulse, flag held",
        {done, lock_timeout}, {1'b0, to_exp});
    chk(cur_f() == ef && pll_range == rg, "R9 fields of running change kept", cur_f(), ef);
    prev_f = ef; prev_rg = rg;
    pll_lock = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(!pll_bypass && !pll_reset && !hold_dn_clk && !busy && !done && !lock_timeout
        && !rejected, "R10 reset outputs low",
        {pll_bypass, pll_reset, hold_dn_clk, busy, done, lock_timeout, rejected}, 0);
    chk(cur_f() == 0 && pll_range == 0, "R10 reset fields zero", cur_f(), 0);

    // directed corners
    run_seq(12'd20,   7'd5,  10'd100, 24'hABCDEF, 7'd2,  3'd0, 8'd0, 1, 3,   1'b0);
    run_seq(12'd1600, 7'd64, 10'd512, 24'hFFFFFF, 7'd64, 3'd7, 8'd2, 0, 0,   1'b0);
    run_seq(12'd500,  7'd1,  10'd1,   24'h000001, 7'd4,  3'd3, 8'd1, 2, 0,   1'b1);
    run_seq(12'd800,  7'd7,  10'd40,  24'h123456, 7'd10, 3'd5, 8'd3, 1, 477, 1'b0);
    run_seq(12'd800,  7'd7,  10'd41,  24'h654321, 7'd12, 3'd2, 8'd1, 1, 478, 1'b0);
    reject_req(12'd19);
    reject_req(12'd1601);
    reject_req(12'd0);

    // random mix
    for (int i = 0; i < 16; i++) begin
      logic [6:0] rd, pd; logic [9:0] fi; int mode, d;
      rd = 7'($urandom_range(1, 64));
      fi = 10'($urandom_range(1, 512));
      pd = 7'(2 * $urandom_range(1, 32));
      mode = ($urandom_range(0, 9) == 0) ? 0 : (($urandom_range(0, 5) == 0) ? 2 : 1);
      d = $urandom_range(1, 60);
      run_seq(12'($urandom_range(20, 1600)), rd, fi, 24'($urandom), pd,
              3'($urandom_range(0, 7)), 8'($urandom_range(0, 6)), mode, d,
              1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) reject_req(12'($urandom_range(1601, 4095)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule